// File: doc/BRIEF.md
# Configurable-Bias 8-bit Float Widener

This block takes one 8-bit floating-point code and produces the exactly equal IEEE single-precision bit pattern. The code can use either of two layouts, chosen by a one-bit format select: four exponent bits with three fraction bits, or five exponent bits with two fraction bits. In both layouts the top bit is the sign. The exponent offset is not fixed. A 6-bit unsigned bias input supplies it, and it can change on any cycle. This lets one set of narrow codes cover very small or moderately large magnitudes, depending on which tensor they hold.

A non-zero exponent field gives a normal value, sign × 2^(field − bias) × 1.fraction. This includes the all-ones field, which is an ordinary finite value. A zero exponent field with a non-zero fraction gives a subnormal value, sign × 2^(−bias) × 0.fraction. The widener renormalises it with a leading-zero count, so the result is a normal single-precision number. A zero field with a zero fraction gives a signed zero. Every input lands exactly on a single-precision value, so the block does no rounding. A flag marks subnormal inputs so that a wider unit can raise its denormal status. A parameter selects a registered output with one cycle of latency, or a purely combinational output.

Top module: `cf8_widen`

## Requirements
- R1: With format select 0 (code bits [6:3] exponent, [2:0] fraction) and a non-zero exponent field e, the output equals (−1)^code[7] × 2^(e − bias) × (1 + fraction/8) exactly.
- R2: A zero exponent field with a non-zero fraction f decodes to (−1)^sign × 2^(−bias) × f/2^k, where k is the fraction width (3 or 2). The result is a normal single-precision number.
- R3: A code whose exponent and fraction are both zero decodes to a zero with the input's sign: 0x00000000 for positive and 0x80000000 for negative.
- R4: The all-ones exponent field decodes to a finite value. The output exponent field is never 0xFF.
- R5: With format select 1 (code bits [6:2] exponent, [1:0] fraction) and a non-zero exponent field e, the output equals (−1)^sign × 2^(e − bias) × (1 + fraction/4) exactly.
- R6: out_denorm is 1 in the same cycle as out_valid exactly when the accepted code has a zero exponent field and a non-zero fraction, and 0 otherwise.
- R7: Every bias from 0 to 63 applies. At bias 63, code 0x08 in format 0 gives 0x20800000, and code 0x7F in format 0 gives 0x27F00000. At bias 0, code 0x7F in format 1 gives 0x4F600000.
- R8: With the registered option, out_valid follows in_valid one cycle later, and a synchronous reset clears out_valid, out_value and out_denorm.
- R9: Output fraction bits [19:0] are always zero. Re-encoding the output into the same layout and bias gives back the original code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input code is present |
| in_fmt | input | 1 | Layout select: 0 = 4-bit exponent, 1 = 5-bit exponent |
| in_bias | input | 6 | Unsigned exponent bias |
| in_code | input | 8 | Packed 8-bit float code |
| out_valid | output | 1 | Result is present |
| out_value | output | 32 | Single-precision result |
| out_denorm | output | 1 | Accepted code was subnormal |

## Verification
The hardest case to reach is the deepest subnormal: a single set low fraction bit together with the largest bias. It needs a two-place normalisation shift and gives the smallest output exponent, 61. A sparse random stimulus seldom lands there at high bias. The bench therefore sweeps every code against every bias in both layouts, which covers each shift depth at each bias. Each result is compared with a value built in real arithmetic and with a re-encoding back to the original code.

// File: rtl/cf8_pkg.sv
package cf8_pkg;
    localparam int CODE_W      = 8;
    localparam int BIAS_W      = 6;
    localparam int EXP_W       = 5;   // widest exponent across the two layouts
    localparam int MAN_W       = 3;   // widest fraction across the two layouts
    localparam int LZ_W        = $clog2(MAN_W + 1);
    localparam int FP_EXP_W    = 8;
    localparam int FP_MAN_W    = 23;
    localparam int FP_EXP_BIAS = 127;
    localparam int FRAC_PAD    = FP_MAN_W - MAN_W;

    typedef enum logic {
        FMT_E4M3 = 1'b0,
        FMT_E5M2 = 1'b1
    } cf8_fmt_e;

    // Common unpacked form: exponent zero-extended, fraction left-aligned
    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } cf8_fields_t;

    typedef struct packed {
        logic                sign;
        logic [FP_EXP_W-1:0] exp;
        logic [FP_MAN_W-1:0] frac;
    } fp32_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [MAN_W-1:0] m);
        logic found;
        lead_zeros = '0;
        found      = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (m[i]) found = 1'b1;
                else      lead_zeros = LZ_W'(lead_zeros + 1'b1);
            end
        end
    endfunction
endpackage

// File: rtl/cf8_split.sv
module cf8_split
    import cf8_pkg::*;
(
    input  cf8_fmt_e          fmt,
    input  logic [CODE_W-1:0] code,
    output cf8_fields_t       fields,
    output logic              is_zero,
    output logic              is_sub
);
    always_comb begin
        fields.sign = code[CODE_W-1];
        unique case (fmt)
            FMT_E4M3: begin
                fields.exp = {1'b0, code[6:3]};
                fields.man = code[2:0];
            end
            default: begin
                fields.exp = code[6:2];
                fields.man = {code[1:0], 1'b0};
            end
        endcase
    end

    assign is_zero = (fields.exp == '0) && (fields.man == '0);
    assign is_sub  = (fields.exp == '0) && (fields.man != '0);
endmodule

// File: rtl/cf8_subnorm.sv
module cf8_subnorm
    import cf8_pkg::*;
(
    input  logic [MAN_W-1:0] man,
    output logic [LZ_W-1:0]  lz,
    output logic [MAN_W-1:0] shifted
);
    assign lz      = lead_zeros(man);
    // shift the leading one out; what remains is the stored fraction
    assign shifted = man << (lz + LZ_W'(1));

    always_comb begin
        if (man != '0) begin
            p_lz_range_r2: assert (lz < LZ_W'(MAN_W) && shifted[MAN_W-1-lz] == 1'b0 || lz < LZ_W'(MAN_W));
        end
    end
endmodule

// File: rtl/cf8_assemble.sv
module cf8_assemble
    import cf8_pkg::*;
(
    input  cf8_fields_t       fields,
    input  logic [BIAS_W-1:0] bias,
    input  logic              is_zero,
    input  logic              is_sub,
    input  logic [LZ_W-1:0]   lz,
    input  logic [MAN_W-1:0]  sub_man,
    output fp32_t             result
);
    localparam logic [FP_EXP_W-1:0] EXP_OFS = FP_EXP_W'(FP_EXP_BIAS);

    logic [FP_EXP_W-1:0] bias_x;
    logic [FP_EXP_W-1:0] exp_norm;
    logic [FP_EXP_W-1:0] exp_sub;

    assign bias_x   = FP_EXP_W'(bias);
    assign exp_norm = EXP_OFS + FP_EXP_W'(fields.exp) - bias_x;
    assign exp_sub  = EXP_OFS - bias_x - FP_EXP_W'(lz) - FP_EXP_W'(1);

    always_comb begin
        result.sign = fields.sign;
        if (is_zero) begin
            result.exp  = '0;
            result.frac = '0;
        end else if (is_sub) begin
            result.exp  = exp_sub;
            result.frac = {sub_man, {FRAC_PAD{1'b0}}};
        end else begin
            result.exp  = exp_norm;
            result.frac = {fields.man, {FRAC_PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/cf8_widen.sv
module cf8_widen
    import cf8_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_fmt,
    input  logic [BIAS_W-1:0] in_bias,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    output logic [31:0]       out_value,
    output logic              out_denorm
);
    cf8_fields_t      fields;
    logic             is_zero;
    logic             is_sub;
    logic [LZ_W-1:0]  lz;
    logic [MAN_W-1:0] sub_man;
    fp32_t            wide;
    cf8_fmt_e         fmt;

    assign fmt = cf8_fmt_e'(in_fmt);

    cf8_split u_split (
        .fmt     (fmt),
        .code    (in_code),
        .fields  (fields),
        .is_zero (is_zero),
        .is_sub  (is_sub)
    );

    cf8_subnorm u_subnorm (
        .man     (fields.man),
        .lz      (lz),
        .shifted (sub_man)
    );

    cf8_assemble u_assemble (
        .fields  (fields),
        .bias    (in_bias),
        .is_zero (is_zero),
        .is_sub  (is_sub),
        .lz      (lz),
        .sub_man (sub_man),
        .result  (wide)
    );

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid  <= 1'b0;
                    out_value  <= '0;
                    out_denorm <= 1'b0;
                end else begin
                    out_valid  <= in_valid;
                    out_value  <= wide;
                    out_denorm <= in_valid & is_sub;
                end
            end

            p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_value  = wide;
            assign out_denorm = in_valid & is_sub;
        end
    endgenerate

    p_finite_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_value[30:23] != 8'hFF);
    p_denorm_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        out_denorm |-> (out_valid && out_value[30:0] != 31'd0));
    p_exp_window_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_value[30:0] != 31'd0) |->
        (out_value[30:23] >= 8'd61 && out_value[30:23] <= 8'd158));
    p_exact_frac_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_value[19:0] == 20'd0);
endmodule

// File: tb/cf8_widen_tb.sv
module cf8_widen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_fmt = 1'b0;
    logic [5:0]  in_bias = '0;
    logic [7:0]  in_code = '0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_denorm;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cf8_widen u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_fmt     (in_fmt),
        .in_bias    (in_bias),
        .in_code    (in_code),
        .out_valid  (out_valid),
        .out_value  (out_value),
        .out_denorm (out_denorm)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    function automatic real pow2(input int k);
        real p = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) p = p * 2.0;
        else        for (int i = 0; i < -k; i++) p = p / 2.0;
        return p;
    endfunction

    // expected value built in real arithmetic, then packed from the double bits
    function automatic logic [31:0] ref_bits(input bit f, input int b, input logic [7:0] c);
        int  ebits = f ? 5 : 4;
        int  mbits = f ? 2 : 3;
        int  e     = int'(c[6:0]) >> mbits;
        int  m     = int'(c[6:0]) & ((1 << mbits) - 1);
        real v;
        logic [63:0] d;
        int  e32;
        if (e == 0) v = (real'(m) / pow2(mbits)) * pow2(-b);
        else        v = (1.0 + real'(m) / pow2(mbits)) * pow2(e - b);
        if (ebits == 0) v = 0.0;
        if (v == 0.0) return {c[7], 31'd0};
        d   = $realtobits(v);
        e32 = int'(d[62:52]) - 1023 + 127;
        return {c[7], e32[7:0], d[51:29]};
    endfunction

    function automatic logic [7:0] reencode(input bit f, input int b, input logic [31:0] v);
        int unb = int'(v[30:23]) - 127 + b;
        logic [3:0] sig4;
        logic [2:0] sig3;
        if (v[30:0] == 31'd0) return {v[31], 7'd0};
        sig4 = {1'b1, v[22:20]};
        sig3 = {1'b1, v[22:21]};
        if (!f) begin
            if (unb >= 1) return {v[31], unb[3:0], v[22:20]};
            return {v[31], 4'd0, 3'(sig4 >> (-unb))};
        end
        if (unb >= 1) return {v[31], unb[4:0], v[22:21]};
        return {v[31], 5'd0, 2'(sig3 >> (-unb))};
    endfunction

    task automatic apply(input bit f, input int b, input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = f;
        in_bias  = 6'(b);
        in_code  = c;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R8 reset value", out_value, 32'd0);
        chk("R8 reset denorm", {31'd0, out_denorm}, 32'd0);
        rst = 1'b0;

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle valid", {31'd0, out_valid}, 32'd0);

        for (int f = 0; f < 2; f++) begin
            for (int b = 0; b < 64; b++) begin
                for (int c = 0; c < 256; c++) begin
                    logic [7:0]  cc = 8'(c);
                    logic [31:0] exp_v;
                    bit          sub;
                    string       tag;
                    int          ef;
                    apply(f[0], b, cc);
                    exp_v = ref_bits(f[0], b, cc);
                    ef    = f ? int'(cc[6:2]) : int'(cc[6:3]);
                    sub   = (ef == 0) && (f ? cc[1:0] != 0 : cc[2:0] != 0);
                    if (ef == 0 && !sub)          tag = "R3 zero";
                    else if (sub)                 tag = "R2 subnormal";
                    else if (ef == (f ? 31 : 15)) tag = "R4 top exponent";
                    else if (f)                   tag = "R5 layout 1-5-2";
                    else                          tag = "R1 layout 1-4-3";
                    chk("R8 valid", {31'd0, out_valid}, 32'd1);
                    chk(tag, out_value, exp_v);
                    chk("R6 denorm flag", {31'd0, out_denorm}, {31'd0, sub});
                    chk("R9 round trip", {24'd0, reencode(f[0], b, out_value)}, {24'd0, cc});
                end
            end
        end

        apply(1'b0, 63, 8'h08);
        chk("R7 bias 63 smallest normal", out_value, 32'h20800000);
        apply(1'b0, 63, 8'h7F);
        chk("R7 bias 63 largest", out_value, 32'h27F00000);
        apply(1'b1, 0, 8'h7F);
        chk("R7 bias 0 wide layout largest", out_value, 32'h4F600000);
        apply(1'b0, 17, 8'h80);
        chk("R3 negative zero", out_value, 32'h80000000);
        apply(1'b0, 63, 8'h01);
        chk("R2 deepest subnormal", out_value, 32'h1E800000);

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 valid drop", {31'd0, out_valid}, 32'd0);
        chk("R6 flag drop", {31'd0, out_denorm}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule